// File: doc/BRIEF.md
# SDRAM mode register and read-latency pipeline

This block is the device-side control of a single-data-rate synchronous DRAM that sits between the command decoder and the memory array. A load-mode command stores a ten-bit mode word taken from the address bus. The block decodes four things from that word: the burst length, the CAS latency, the write-burst policy and the operating mode. Every READ or WRITE then starts a burst of column addresses toward the array. For reads, the block captures the array data and delivers it on the data output after the programmed latency. It drives the data-bus output enable so that the bus turns around one cycle ahead of the first word.

Mode words that are reserved or that select a test mode raise an illegal-mode flag. While the flag is set, READ and WRITE are dropped. A clock-rate parameter can rule out the shorter latency. Sequential bursts wrap inside their aligned block. A new READ or WRITE cuts the burst in progress short, and reads already in flight still complete at their own latency.

Top module: `sdram_mode_pipe`

## Requirements
- R1: After reset, the mode is burst length 1, latency 3 and normal operation. `modeIllegal`, `dqOe` and `burstValid` are 0.
- R2: A LOAD command (`cmdIn`=1) stores `addrIn` as the mode word at that edge. The fields are: burst code in bits 2:0 (0→1, 1→2, 2→4, 3→8 beats), burst type in bit 3, latency code in bits 6:4 (2 or 3), operating mode in bits 8:7, and write policy in bit 9.
- R3: A READ (`cmdIn`=2) or WRITE (`cmdIn`=3) registered at edge n presents `colIn` on `burstCol` after edge n. After edge n+k it presents the column at offset k, counted sequentially and wrapping inside the aligned block of burst-length size. `burstValid` is high for exactly those cycles.
- R4: For a READ at edge n with latency m, the word the array returns for beat k is on `dqOut` after edge n+m+k.
- R5: `dqOe` rises after edge n+m-1, one cycle before the first word. It falls after edge n+m+BL unless a following read keeps the stream without a gap.
- R6: With bit 9 = 1, every WRITE is a single beat. READs still use the programmed burst length.
- R7: With bit 9 = 0, WRITEs use the programmed burst length and `burstWrite` is 1 during their beats. Writes never raise `dqOe`.
- R8: `modeIllegal` is 1 when any of these holds: bits 8:7 ≠ 0, the burst code is above 3, or the latency code is neither 2 nor 3. While it is 1, READ and WRITE start no burst.
- R9: When `CLK_MHZ` exceeds `CL2_MAX_MHZ`, latency code 2 sets `modeIllegal`.
- R10: A READ or WRITE during a burst ends that burst's column sequence and starts the new one. Read words already issued still appear at their latency. Back-to-back read bursts keep `dqOe` high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdIn | input | 2 | Decoded command: 0 NOP, 1 LOAD, 2 READ, 3 WRITE |
| addrIn | input | 10 | Mode-word bits of the address bus |
| colIn | input | COL_W | Start column for READ/WRITE |
| arrData | input | DATA_W | Array read data for the column on `burstCol` this cycle |
| dqOe | output | 1 | Data-bus output enable |
| dqOut | output | DATA_W | Read data word |
| burstCol | output | COL_W | Column address of the current burst beat |
| burstValid | output | 1 | `burstCol` carries a beat |
| burstWrite | output | 1 | The current beat belongs to a write |
| modeIllegal | output | 1 | The stored mode word is reserved or not allowed |

## Verification
Take a command registered at edge n. Its column beats are due after edges n through n+BL-1. For a read, the enable is due after edge n+m-1 and beat k's word after edge n+m+k. The mode flag follows the LOAD edge by one cycle. The bench keeps a reference model that is stepped once per edge, using the command it latched at that edge. The model books each predicted enable and data word into a slot for the exact future edge. The outputs are compared on the falling edge that follows each rising edge, so every result is sampled in the cycle it is due. The random phases mix back-to-back and truncating commands. The directed phases cover wrap at the block edge, single-beat writes, each reserved field and the clock-rate rule, which is exercised through a second instance with a faster clock parameter.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_READ  = 2'd2,
    CMD_WRITE = 2'd3
  } cmd_e;

  localparam int MODE_W  = 10;
  localparam int WRAP_W  = 3;
  localparam int MAX_LAT = 3;
  localparam int STAGES  = MAX_LAT - 1;

  typedef struct packed {
    logic              start;
    logic              step;
    logic              beatRd;
    logic              lat3;
    logic [WRAP_W-1:0] wrapMask;
  } strobe_t;

endpackage

// File: rtl/sdm_ctrl.sv
module sdm_ctrl
  import sdm_pkg::*;
#(
  parameter int CLK_MHZ     = 133,
  parameter int CL2_MAX_MHZ = 133
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmdIn,
  input  logic [MODE_W-1:0] addrIn,
  output strobe_t           strb,
  output logic              burstValid,
  output logic              burstWrite,
  output logic              modeIllegal
);

  localparam logic [MODE_W-1:0] RESET_MODE = 10'b00_0011_0000;
  localparam bit CL2_OK = (CLK_MHZ <= CL2_MAX_MHZ);

  cmd_e              cmd;
  logic [MODE_W-1:0] modeWord;
  logic [2:0]        blCode;
  logic [2:0]        clCode;
  logic [1:0]        opMode;
  logic              wrSingle;
  logic [2:0]        blMask;
  logic [2:0]        beatsLeft;
  logic [2:0]        curMask;
  logic              isRw;
  logic              isWr;
  logic              goCmd;

  assign cmd      = cmd_e'(cmdIn);
  assign blCode   = modeWord[2:0];
  assign clCode   = modeWord[6:4];
  assign opMode   = modeWord[8:7];
  assign wrSingle = modeWord[9];

  always_comb begin
    unique case (blCode)
      3'd0:    blMask = 3'd0;
      3'd1:    blMask = 3'd1;
      3'd2:    blMask = 3'd3;
      default: blMask = 3'd7;
    endcase
  end

  always_comb begin
    modeIllegal = 1'b0;
    if (blCode > 3'd3) modeIllegal = 1'b1;
    if (opMode != 2'b00) modeIllegal = 1'b1;
    if (!((clCode == 3'd3) || ((clCode == 3'd2) && CL2_OK))) modeIllegal = 1'b1;
  end

  assign isRw  = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign isWr  = (cmd == CMD_WRITE);
  assign goCmd = isRw && !modeIllegal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeWord   <= RESET_MODE;
      burstValid <= 1'b0;
      burstWrite <= 1'b0;
      beatsLeft  <= '0;
      curMask    <= '0;
    end else begin
      if (cmd == CMD_LOAD) modeWord <= addrIn;
      if (goCmd) begin
        burstValid <= 1'b1;
        burstWrite <= isWr;
        if (isWr && wrSingle) begin
          beatsLeft <= '0;
          curMask   <= '0;
        end else begin
          beatsLeft <= blMask;
          curMask   <= blMask;
        end
      end else if (burstValid) begin
        if (beatsLeft == '0) begin
          burstValid <= 1'b0;
          burstWrite <= 1'b0;
        end else begin
          beatsLeft <= beatsLeft - 3'd1;
        end
      end
    end
  end

  always_comb begin
    strb.start    = goCmd;
    strb.step     = burstValid && (beatsLeft != '0) && !goCmd;
    strb.beatRd   = burstValid && !burstWrite;
    strb.lat3     = (clCode == 3'd3);
    strb.wrapMask = curMask;
  end

  // R2: the mode word seen after a LOAD edge is the address presented at it
  a_r2_mode_capture: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_LOAD) |=> (modeWord == $past(addrIn)));

  // R8: no burst can start from idle while the mode is flagged
  a_r8_illegal_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (modeIllegal && !burstValid && isRw) |=> !burstValid);

  // R6: a single-location write followed by a NOP occupies one beat only
  a_r6_single_write: assert property (@(posedge clk) disable iff (!rstN)
    (goCmd && isWr && wrSingle) ##1 (cmd == CMD_NOP) |=> !burstValid);

endmodule

// File: rtl/sdm_dpath.sv
module sdm_dpath
  import sdm_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [COL_W-1:0]  colIn,
  input  logic [DATA_W-1:0] arrData,
  output logic [COL_W-1:0]  burstCol,
  output logic              dqOe,
  output logic [DATA_W-1:0] dqOut
);

  logic [COL_W-1:0]  maskW;
  logic [COL_W-1:0]  colInc;
  logic [COL_W-1:0]  colNext;
  logic [STAGES-1:0] stV;
  logic [DATA_W-1:0] stD [STAGES];
  logic              tapV;
  logic              preV;
  logic [DATA_W-1:0] tapD;

  assign maskW   = COL_W'(strb.wrapMask);
  assign colInc  = burstCol + COL_W'(1);
  assign colNext = (burstCol & ~maskW) | (colInc & maskW);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstCol <= '0;
    end else if (strb.start) begin
      burstCol <= colIn;
    end else if (strb.step) begin
      burstCol <= colNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stV <= '0;
      for (int i = 0; i < STAGES; i++) stD[i] <= '0;
    end else begin
      stV[0] <= strb.beatRd;
      stD[0] <= arrData;
      for (int i = 1; i < STAGES; i++) begin
        stV[i] <= stV[i-1];
        stD[i] <= stD[i-1];
      end
    end
  end

  // tap for the word due next edge, and the one a cycle behind it
  assign tapV = strb.lat3 ? stV[1] : stV[0];
  assign tapD = strb.lat3 ? stD[1] : stD[0];
  assign preV = strb.lat3 ? stV[0] : strb.beatRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dqOe  <= 1'b0;
      dqOut <= '0;
    end else begin
      dqOe <= preV || tapV;
      if (tapV) dqOut <= tapD;
    end
  end

  // R3: stepping never leaves the aligned block of the burst
  a_r3_block_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> (burstCol[COL_W-1:WRAP_W] == $past(burstCol[COL_W-1:WRAP_W])));

  // R5: the enable leads the data by a cycle, so it never lasts a single cycle
  a_r5_oe_preamble: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqOe) |=> dqOe);

  // R4: a new data word only ever appears with the bus driven
  a_r4_data_under_oe: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dqOut) |-> dqOe);

endmodule

// File: rtl/sdram_mode_pipe.sv
module sdram_mode_pipe
  import sdm_pkg::*;
#(
  parameter int COL_W       = 10,
  parameter int DATA_W      = 16,
  parameter int CLK_MHZ     = 133,
  parameter int CL2_MAX_MHZ = 133
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmdIn,
  input  logic [MODE_W-1:0] addrIn,
  input  logic [COL_W-1:0]  colIn,
  input  logic [DATA_W-1:0] arrData,
  output logic              dqOe,
  output logic [DATA_W-1:0] dqOut,
  output logic [COL_W-1:0]  burstCol,
  output logic              burstValid,
  output logic              burstWrite,
  output logic              modeIllegal
);

  strobe_t strb;

  sdm_ctrl #(
    .CLK_MHZ    (CLK_MHZ),
    .CL2_MAX_MHZ(CL2_MAX_MHZ)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdIn      (cmdIn),
    .addrIn     (addrIn),
    .strb       (strb),
    .burstValid (burstValid),
    .burstWrite (burstWrite),
    .modeIllegal(modeIllegal)
  );

  sdm_dpath #(
    .COL_W (COL_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .colIn   (colIn),
    .arrData (arrData),
    .burstCol(burstCol),
    .dqOe    (dqOe),
    .dqOut   (dqOut)
  );

endmodule

// File: tb/sim_sdram_mode_pipe.sv
module sim_sdram_mode_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W  = 10;
  localparam int DATA_W = 16;
  localparam int FAST_MHZ = 143;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cmdIn = 2'd0;
  logic [9:0] addrIn = '0;
  logic [COL_W-1:0] colIn = '0;
  logic [DATA_W-1:0] arrData;
  logic dqOe, burstValid, burstWrite, modeIllegal;
  logic [DATA_W-1:0] dqOut;
  logic [COL_W-1:0] burstCol;
  logic dqOeHi, burstValidHi, burstWriteHi, modeIllegalHi;
  logic [DATA_W-1:0] dqOutHi;
  logic [COL_W-1:0] burstColHi;

  sdram_mode_pipe u0 (
    .clk(clk), .rstN(rstN), .cmdIn(cmdIn), .addrIn(addrIn), .colIn(colIn),
    .arrData(arrData), .dqOe(dqOe), .dqOut(dqOut), .burstCol(burstCol),
    .burstValid(burstValid), .burstWrite(burstWrite), .modeIllegal(modeIllegal));

  sdram_mode_pipe #(.CLK_MHZ(FAST_MHZ)) u1 (
    .clk(clk), .rstN(rstN), .cmdIn(cmdIn), .addrIn(addrIn), .colIn(colIn),
    .arrData(arrData), .dqOe(dqOeHi), .dqOut(dqOutHi), .burstCol(burstColHi),
    .burstValid(burstValidHi), .burstWrite(burstWriteHi), .modeIllegal(modeIllegalHi));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] arrOf(input logic [COL_W-1:0] c);
    return {c[5:0], c} ^ 16'h5AC3;
  endfunction

  function automatic bit illegalOf(input logic [9:0] m, input int mhz);
    bit bad = 0;
    if (m[2:0] > 3'd3) bad = 1;
    if (m[8:7] != 2'b00) bad = 1;
    if (!((m[6:4] == 3'd3) || ((m[6:4] == 3'd2) && (mhz <= 133)))) bad = 1;
    return bad;
  endfunction

  assign arrData = arrOf(burstCol);

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;
  string curTag = "R1";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // model state
  int cyc = 0;
  logic [1:0] cmdL = 0;
  logic [9:0] addrL = 0;
  logic [COL_W-1:0] colL = 0;
  bit latV = 0;
  bit modelOn = 0;
  logic [9:0] mMode = 10'h030;
  bit active = 0, wr = 0;
  logic [COL_W-1:0] mCol = 0, mask = 0;
  int left = 0, lat = 3;
  bit expOe [16];
  bit expDqV [16];
  logic [DATA_W-1:0] expDq [16];

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    cmdL  <= cmdIn;
    addrL <= addrIn;
    colL  <= colIn;
    latV  <= rstN;
  end

  always @(negedge clk) begin : mdl
    bit go;
    int bl, s;
    if (latV && modelOn) begin
      go = ((cmdL == 2'd2) || (cmdL == 2'd3)) && !illegalOf(mMode, 133);
      bl = 1 << mMode[1:0];
      if (go) begin
        active = 1;
        wr = (cmdL == 2'd3);
        if (wr && mMode[9]) begin left = 0; mask = 0; end
        else begin left = bl - 1; mask = COL_W'(bl - 1); end
        mCol = colL;
        lat = (mMode[6:4] == 3'd3) ? 3 : 2;
      end else if (active) begin
        if (left == 0) active = 0;
        else begin
          left--;
          mCol = (mCol & ~mask) | ((mCol + 1'b1) & mask);
        end
      end
      if (cmdL == 2'd1) mMode = addrL;
      if (active && !wr) begin
        expOe[(cyc + lat - 1) % 16] = 1;
        expOe[(cyc + lat) % 16] = 1;
        expDq[(cyc + lat) % 16] = arrOf(mCol);
        expDqV[(cyc + lat) % 16] = 1;
      end
      s = cyc % 16;
      chk(burstValid == active, {curTag, " burstValid"}, burstValid, active);
      if (active) begin
        chk(burstCol == mCol, {curTag, " burstCol"}, burstCol, mCol);
        chk(burstWrite == wr, {curTag, " burstWrite"}, burstWrite, wr);
      end
      chk(dqOe == expOe[s], {curTag, " dqOe"}, dqOe, expOe[s]);
      if (expDqV[s]) chk(dqOut == expDq[s], {curTag, " dqOut"}, dqOut, expDq[s]);
      chk(modeIllegal == illegalOf(mMode, 133), {curTag, " modeIllegal"}, modeIllegal, illegalOf(mMode, 133));
      chk(modeIllegalHi == illegalOf(mMode, FAST_MHZ), "R9 modeIllegal fast clock", modeIllegalHi, illegalOf(mMode, FAST_MHZ));
      expOe[s] = 0;
      expDqV[s] = 0;
    end
  end

  task automatic drive(input logic [1:0] c, input logic [9:0] a, input logic [COL_W-1:0] col);
    @(negedge clk);
    cmdIn = c; addrIn = a; colIn = col;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(2'd0, 10'h0, '0);
  endtask

  task automatic loadMode(input logic [9:0] w);
    drive(2'd1, w, '0);
    idle(1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin expOe[i] = 0; expDqV[i] = 0; expDq[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk(modeIllegal == 0, "R1 modeIllegal after reset", modeIllegal, 0);
    chk(dqOe == 0, "R1 dqOe after reset", dqOe, 0);
    chk(burstValid == 0, "R1 burstValid after reset", burstValid, 0);
    modelOn = 1;
    curTag = "R1";
    drive(2'd2, 10'h0, 10'h012); idle(8);

    curTag = "R2";
    loadMode(10'h022); drive(2'd2, 10'h0, 10'h00E); idle(8);

    curTag = "R3";
    loadMode(10'h033); drive(2'd2, 10'h0, 10'h005); idle(14);
    drive(2'd2, 10'h0, 10'h3FF); idle(14);

    curTag = "R4";
    loadMode(10'h020); drive(2'd2, 10'h0, 10'h044); idle(6);
    loadMode(10'h031); drive(2'd2, 10'h0, 10'h045); idle(8);

    curTag = "R5";
    loadMode(10'h021); drive(2'd2, 10'h0, 10'h0A1); idle(6);
    loadMode(10'h020);
    drive(2'd2, 10'h0, 10'h010); idle(2); drive(2'd2, 10'h0, 10'h020); idle(6);

    curTag = "R6";
    loadMode(10'h232); drive(2'd3, 10'h0, 10'h008); idle(4);
    drive(2'd2, 10'h0, 10'h008); idle(10);

    curTag = "R7";
    loadMode(10'h032); drive(2'd3, 10'h0, 10'h009); idle(8);

    curTag = "R10";
    loadMode(10'h023); drive(2'd2, 10'h0, 10'h000); idle(2);
    drive(2'd2, 10'h0, 10'h010); idle(12);
    loadMode(10'h031);
    drive(2'd2, 10'h0, 10'h100); idle(1); drive(2'd2, 10'h0, 10'h102); idle(1);
    drive(2'd2, 10'h0, 10'h104); idle(10);
    loadMode(10'h032); drive(2'd2, 10'h0, 10'h000); drive(2'd3, 10'h0, 10'h014); idle(12);

    curTag = "R8";
    loadMode(10'h0B0);
    chk(modeIllegal == 1, "R8 operating mode 01", modeIllegal, 1);
    drive(2'd2, 10'h0, 10'h003); idle(6);
    loadMode(10'h035);
    chk(modeIllegal == 1, "R8 burst code 5", modeIllegal, 1);
    drive(2'd3, 10'h0, 10'h003); idle(6);
    loadMode(10'h015);
    chk(modeIllegal == 1, "R8 latency code 1", modeIllegal, 1);
    loadMode(10'h040);
    chk(modeIllegal == 1, "R8 latency code 4", modeIllegal, 1);
    loadMode(10'h130);
    chk(modeIllegal == 1, "R8 operating mode 10", modeIllegal, 1);
    loadMode(10'h030);
    chk(modeIllegal == 0, "R8 legal word clears flag", modeIllegal, 0);

    curTag = "R9";
    loadMode(10'h020);
    chk(modeIllegal == 0, "R9 latency 2 at slow clock", modeIllegal, 0);
    chk(modeIllegalHi == 1, "R9 latency 2 at fast clock", modeIllegalHi, 1);
    loadMode(10'h030);
    chk(modeIllegalHi == 0, "R9 latency 3 at fast clock", modeIllegalHi, 0);

    curTag = "R10";
    for (int b = 0; b < 10; b++) begin
      logic [9:0] w;
      w = {1'($urandom % 2), 2'b00, ($urandom % 2) ? 3'd3 : 3'd2, 1'($urandom % 2), 3'($urandom % 4)};
      loadMode(w); idle(1);
      for (int k = 0; k < 40; k++) begin
        int r;
        r = $urandom % 8;
        if (r < 3) drive(2'd0, 10'h0, '0);
        else if (r < 6) drive(2'd2, 10'h0, COL_W'($urandom));
        else drive(2'd3, 10'h0, COL_W'($urandom));
      end
      idle(14);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule